// File: doc/BRIEF.md
# Open-Loop Memory Activation Throttler

The block watches the row-activation stream of a DRAM scheduler and slices time into repeating windows whose length in cycles is programmable. It counts the activations granted in each window. At the close of a window that count is compared with a programmable global ceiling. A window that goes past the ceiling puts the block into a throttled mode, and that mode lasts for a fixed run of sixteen windows. While throttled, the block lowers its grant output once the activations in the current window reach a cap. The cap is one of two programmable values, and a select input picks which one applies.

The block is open-loop and keeps no memory of past windows. Only the count of the window that has just closed matters. A small write port changes the four settings while traffic runs, and each new value takes effect on the next cycle. The port enforces a minimum spacing between accepted writes. It drops any write that comes too early and records the event in a sticky error bit.

The controller has two states. `ST_FREE` grants every request. `ST_THROTTLE` enforces the cap. There are three transitions: *enter* (`ST_FREE` to `ST_THROTTLE` at the close of an over-ceiling window), *advance/restart* (`ST_THROTTLE` to itself at each window close, counting the span or starting it again), and *release* (`ST_THROTTLE` to `ST_FREE` at the close of the sixteenth window when that window was not over the ceiling).

Top module: `act_throttle`

## Requirements
- R1: A window closes on the cycle in which the window cycle counter reaches the programmed length minus one. The activation count is cleared at each close, and an activation granted on the closing cycle belongs to the window that is closing.
- R2: When the activations in a closing window are strictly greater than the global ceiling, `throttled` is 1 from the next cycle on (transition *enter*).
- R3: A window whose count equals the ceiling does not start throttling.
- R4: Throttling covers exactly 16 windows. At the close of the 16th window the block returns to `ST_FREE`, unless that window was itself over the ceiling, in which case a fresh 16-window span begins.
- R5: Over-ceiling windows among the first 15 windows of a span neither lengthen nor restart the span.
- R6: In `ST_THROTTLE`, `act_grant` is 1 only while the current window's count is below the cap. The cap is the high cap when `sel_high`=1 and the low cap when `sel_high`=0.
- R7: In `ST_FREE`, `act_grant` is always 1. After reset the outputs are `act_grant`=1, `throttled`=0, `cfg_busy`=0 and `cfg_err`=0.
- R8: An accepted write changes its setting from the next cycle on. This holds in the middle of a span too, and the write does not restart the span.
- R9: A write that arrives fewer than 80 cycles after the last accepted write is dropped, and `cfg_err` becomes 1 and stays 1 until reset. The first write after reset is always accepted.
- R10: After an accepted write, `cfg_busy` is 1 for the next 40 cycles and 0 after that.
- R11: Address map: 0 selects the window length, 1 the global ceiling, 2 the low cap and 3 the high cap. A window length of 0 behaves as 1, so every cycle closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_req | input | 1 | Scheduler wants to issue an activation this cycle |
| sel_high | input | 1 | 1 selects the high cap while throttled, 0 selects the low cap |
| cfg_wr | input | 1 | Write strobe for the setting port |
| cfg_addr | input | 2 | Setting index (see R11) |
| cfg_data | input | DATA_W | Value to be written |
| act_grant | output | 1 | The activation may issue; a granted request counts |
| throttled | output | 1 | Global throttle flag |
| cfg_busy | output | 1 | An accepted update is still completing |
| cfg_err | output | 1 | Sticky flag for a spacing violation |

## Verification
Two things can happen on the same cycle as a window close: a granted activation, and a setting write. The closing compare must count the activation and must use the ceiling that was in place before the write. The bench provokes both with random request and write traffic over short windows, so closes often line up with activations and with writes. A cycle-level reference model in the bench follows the same rules from the requirements and judges every cycle. A second coincidence, an over-ceiling 16th window, is reached by the same random traffic and decides whether the span restarts.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [0:0] {
        ST_FREE     = 1'b0,
        ST_THROTTLE = 1'b1
    } thr_state_e;

    localparam int unsigned NUM_SETTINGS = 4;
    localparam logic [1:0] A_WIN_LEN  = 2'd0;
    localparam logic [1:0] A_GLOB_LIM = 2'd1;
    localparam logic [1:0] A_LO_CAP   = 2'd2;
    localparam logic [1:0] A_HI_CAP   = 2'd3;

endpackage

// File: rtl/thr_cfg.sv
module thr_cfg
    import thr_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned WR_GAP   = 80,
    parameter int unsigned WR_LAT   = 40,
    parameter int unsigned WIN_RST  = 64,
    parameter int unsigned GLOB_RST = 8,
    parameter int unsigned LO_RST   = 2,
    parameter int unsigned HI_RST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    output logic [DATA_W-1:0] win_len,
    output logic [DATA_W-1:0] glob_lim,
    output logic [DATA_W-1:0] lo_cap,
    output logic [DATA_W-1:0] hi_cap,
    output logic              spacing_ok,
    output logic              cfg_busy,
    output logic              cfg_err
);
    localparam int unsigned GAP_W = $clog2(WR_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(WR_GAP);
    localparam logic [GAP_W-1:0] LAT_END  = GAP_W'(WR_LAT);
    localparam logic [DATA_W-1:0] RST_V [NUM_SETTINGS] = '{
        DATA_W'(WIN_RST), DATA_W'(GLOB_RST), DATA_W'(LO_RST), DATA_W'(HI_RST)
    };

    logic [GAP_W-1:0]  gap_q;
    logic [DATA_W-1:0] set_q [NUM_SETTINGS];
    logic              wr_take;

    // cycles since the last accepted write, held at WR_GAP once reached
    assign spacing_ok = (gap_q == GAP_FULL);
    assign wr_take    = cfg_wr && spacing_ok;
    assign cfg_busy   = (gap_q <= LAT_END);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= GAP_FULL;
            cfg_err <= 1'b0;
        end else begin
            if (wr_take) begin
                gap_q <= GAP_W'(1);
            end else if (gap_q != GAP_FULL) begin
                gap_q <= gap_q + GAP_W'(1);
            end
            if (cfg_wr && !spacing_ok) begin
                cfg_err <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_SETTINGS; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                set_q[g] <= RST_V[g];
            end else if (wr_take && (cfg_addr == 2'(g))) begin
                set_q[g] <= cfg_data;
            end
        end
    end

    assign win_len  = set_q[A_WIN_LEN];
    assign glob_lim = set_q[A_GLOB_LIM];
    assign lo_cap   = set_q[A_LO_CAP];
    assign hi_cap   = set_q[A_HI_CAP];

endmodule

// File: rtl/thr_window.sv
module thr_window #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] win_len,
    input  logic              act_fire,
    output logic              win_end,
    output logic [DATA_W-1:0] act_cnt,
    output logic [DATA_W-1:0] cnt_nxt
);
    localparam logic [DATA_W-1:0] CNT_MAX = '1;

    logic [DATA_W-1:0] win_q;
    logic [DATA_W-1:0] last_idx;

    // a zero length acts as one cycle
    assign last_idx = (win_len == '0) ? '0 : win_len - DATA_W'(1);
    assign win_end  = (win_q >= last_idx);
    assign cnt_nxt  = (act_fire && (act_cnt != CNT_MAX)) ? act_cnt + DATA_W'(1) : act_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            act_cnt <= '0;
        end else if (win_end) begin
            win_q   <= '0;
            act_cnt <= '0;
        end else begin
            win_q   <= win_q + DATA_W'(1);
            act_cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/thr_ctrl.sv
module thr_ctrl
    import thr_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SPAN   = 16,
    localparam int unsigned SPAN_W = $clog2(SPAN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_end,
    input  logic [DATA_W-1:0] cnt_nxt,
    input  logic [DATA_W-1:0] act_cnt,
    input  logic [DATA_W-1:0] glob_lim,
    input  logic [DATA_W-1:0] lo_cap,
    input  logic [DATA_W-1:0] hi_cap,
    input  logic              sel_high,
    output logic              act_grant,
    output logic              throttled,
    output logic [SPAN_W-1:0] span_cnt
);
    localparam logic [SPAN_W-1:0] SPAN_LAST = SPAN_W'(SPAN - 1);

    thr_state_e        state_q, state_d;
    logic [SPAN_W-1:0] span_d;
    logic              over;
    logic [DATA_W-1:0] cap;

    assign over = (cnt_nxt > glob_lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_FREE;
            span_cnt <= '0;
        end else begin
            state_q  <= state_d;
            span_cnt <= span_d;
        end
    end

    always_comb begin
        state_d = state_q;
        span_d  = span_cnt;
        unique case (state_q)
            ST_FREE: begin
                if (win_end && over) begin      // enter
                    state_d = ST_THROTTLE;
                    span_d  = '0;
                end
            end
            ST_THROTTLE: begin
                if (win_end) begin
                    if (span_cnt == SPAN_LAST) begin
                        span_d = '0;
                        if (!over) begin        // release
                            state_d = ST_FREE;
                        end                     // else restart
                    end else begin              // advance
                        span_d = span_cnt + SPAN_W'(1);
                    end
                end
            end
        endcase
    end

    always_comb begin
        cap       = sel_high ? hi_cap : lo_cap;
        throttled = (state_q == ST_THROTTLE);
        act_grant = !throttled || (act_cnt < cap);
    end

endmodule

// File: rtl/act_throttle.sv
module act_throttle #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned SPAN     = 16,
    parameter int unsigned WR_GAP   = 80,
    parameter int unsigned WR_LAT   = 40,
    parameter int unsigned WIN_RST  = 64,
    parameter int unsigned GLOB_RST = 8,
    parameter int unsigned LO_RST   = 2,
    parameter int unsigned HI_RST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_req,
    input  logic              sel_high,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              act_grant,
    output logic              throttled,
    output logic              cfg_busy,
    output logic              cfg_err
);
    localparam int unsigned SPAN_W = $clog2(SPAN + 1);

    logic [DATA_W-1:0] win_len, glob_lim, lo_cap, hi_cap;
    logic [DATA_W-1:0] act_cnt, cnt_nxt;
    logic [SPAN_W-1:0] span_cnt;
    logic              win_end, wr_ok, act_fire;

    assign act_fire = act_req && act_grant;

    thr_cfg #(
        .DATA_W(DATA_W), .WR_GAP(WR_GAP), .WR_LAT(WR_LAT),
        .WIN_RST(WIN_RST), .GLOB_RST(GLOB_RST), .LO_RST(LO_RST), .HI_RST(HI_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .win_len(win_len), .glob_lim(glob_lim),
        .lo_cap(lo_cap), .hi_cap(hi_cap), .spacing_ok(wr_ok),
        .cfg_busy(cfg_busy), .cfg_err(cfg_err)
    );

    thr_window #(.DATA_W(DATA_W)) u_win (
        .clk(clk), .rst_n(rst_n), .win_len(win_len), .act_fire(act_fire),
        .win_end(win_end), .act_cnt(act_cnt), .cnt_nxt(cnt_nxt)
    );

    thr_ctrl #(.DATA_W(DATA_W), .SPAN(SPAN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .win_end(win_end), .cnt_nxt(cnt_nxt),
        .act_cnt(act_cnt), .glob_lim(glob_lim), .lo_cap(lo_cap),
        .hi_cap(hi_cap), .sel_high(sel_high), .act_grant(act_grant),
        .throttled(throttled), .span_cnt(span_cnt)
    );

endmodule

// File: rtl/act_throttle_chk.sv
module act_throttle_chk #(
    parameter int unsigned SPAN = 16,
    localparam int unsigned SPAN_W = $clog2(SPAN + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              act_grant,
    input logic              throttled,
    input logic              cfg_busy,
    input logic              cfg_err,
    input logic              cfg_wr,
    input logic              wr_ok,
    input logic              win_end,
    input logic [SPAN_W-1:0] span_cnt
);
    p_free_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !throttled |-> act_grant);

    p_wr_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && wr_ok) |=> cfg_busy);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_early_wr_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !wr_ok) |=> cfg_err);

    p_enter_on_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(throttled) |-> $past(win_end));

    p_release_after_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttled) |-> ($past(win_end) && ($past(span_cnt) == SPAN_W'(SPAN - 1))));

endmodule

bind act_throttle act_throttle_chk #(.SPAN(SPAN)) u_chk (
    .clk(clk), .rst_n(rst_n), .act_grant(act_grant), .throttled(throttled),
    .cfg_busy(cfg_busy), .cfg_err(cfg_err), .cfg_wr(cfg_wr), .wr_ok(wr_ok),
    .win_end(win_end), .span_cnt(span_cnt)
);

// File: tb/act_throttle_test.sv
`timescale 1ns/1ps
module act_throttle_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_req = 1'b0, sel_high = 1'b0, cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        act_grant, throttled, cfg_busy, cfg_err;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    act_throttle uut (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .sel_high(sel_high),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .act_grant(act_grant), .throttled(throttled),
        .cfg_busy(cfg_busy), .cfg_err(cfg_err)
    );

    // reference model built from the requirements
    int  m_set [4];
    int  m_win, m_act, m_span, m_gap, m_nxt, m_last;
    bit  m_thr, m_err, m_fire, m_over;

    function automatic bit exp_grant();
        int cap = sel_high ? m_set[3] : m_set[2];
        return !m_thr || (m_act < cap);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_set[0] = 64; m_set[1] = 8; m_set[2] = 2; m_set[3] = 4;
            m_win = 0; m_act = 0; m_span = 0; m_gap = 80; m_thr = 0; m_err = 0;
        end else begin
            m_fire = act_req && exp_grant();
            m_nxt  = (m_fire && m_act != 65535) ? m_act + 1 : m_act;
            m_last = (m_set[0] == 0) ? 0 : m_set[0] - 1;
            if (m_win >= m_last) begin
                m_over = m_nxt > m_set[1];
                m_win = 0; m_act = 0;
                if (!m_thr) begin
                    if (m_over) begin m_thr = 1; m_span = 0; end
                end else if (m_span == 15) begin
                    m_span = 0;
                    if (!m_over) m_thr = 0;
                end else m_span++;
            end else begin
                m_win++; m_act = m_nxt;
            end
            if (cfg_wr && m_gap == 80) begin
                m_set[cfg_addr] = cfg_data; m_gap = 1;
            end else begin
                if (cfg_wr) m_err = 1;
                if (m_gap < 80) m_gap++;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        cfg_wr = 1'b1; cfg_addr = 2'(a); cfg_data = 16'(d);
    endtask

    initial begin
        int last_wr = 400;
        int gap_tgt = 100;
        int thr_cycles = 0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R7 reset grant", act_grant, 1);
        check("R7 reset throttled", throttled, 0);
        check("R7 reset busy", cfg_busy, 0);
        check("R7 reset err", cfg_err, 0);

        for (int cyc = 0; cyc < 5400; cyc++) begin
            @(negedge clk);
            cfg_wr = 1'b0; act_req = 1'b0;
            sel_high = 1'($urandom_range(0, 1));
            if (cyc < 500) begin
                if (cyc == 100) wr(0, 20);
                if (cyc == 150) wr(1, 3);           // too early: dropped
                if (cyc == 200) wr(1, 5);
                if (cyc == 300) wr(2, 2);
                if (cyc == 400) wr(3, 4);
            end else if (cyc < 4000) begin
                act_req = ($urandom_range(0, 99) < 45);
                if (cyc < 3850 && cyc - last_wr >= gap_tgt) begin
                    int a = $urandom_range(1, 3);
                    wr(a, (a == 1) ? $urandom_range(2, 8) : $urandom_range(0, 6));
                    last_wr = cyc;
                    gap_tgt = $urandom_range(60, 140);
                end
            end else if (cyc < 4900) begin
                if (cyc == 4000) wr(0, 0);
                if (cyc == 4100) wr(1, 0);
                if (cyc == 4200) act_req = 1'b1;
                if (cyc == 4300) wr(0, 10);
                if (cyc == 4400) wr(1, 1);
            end else begin
                sel_high = 1'b0;
                act_req = (cyc < 4930);
            end
            #1;
            check("R6 R7 R8 act_grant", act_grant, exp_grant());
            check("R1 R2 R3 R4 R5 throttled", throttled, m_thr);
            check("R10 cfg_busy", cfg_busy, m_gap <= 40);
            check("R9 cfg_err", cfg_err, m_err);
            if (cyc == 101) check("R10 busy first cycle", cfg_busy, 1);
            if (cyc == 140) check("R10 busy 40th cycle", cfg_busy, 1);
            if (cyc == 141) check("R10 busy released", cfg_busy, 0);
            if (cyc == 151) check("R9 early write flagged", cfg_err, 1);
            if (cyc == 4201) check("R11 one-cycle window throttles", throttled, 1);
            if (cyc >= 4900 && cyc < 5300 && throttled) thr_cycles++;
        end
        check("R4 R5 span of 16 windows of 10 cycles", thr_cycles, 160);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule